// File: doc/BRIEF.md
# Digital Soft-Start and Soft-Stop Ramp Sequencer

This block brings one regulator output up and down in a controlled way. It does this by moving a digital target-voltage code instead of switching the output to the setpoint at once. A start is accepted only when all of these hold: the run pin is high, the on command is set, initialisation has finished, the input voltage is good, and no shutdown condition is active. The block then waits out a programmed turn-on delay. After that it ramps the target code from zero to the commanded setpoint over the programmed rise time, with the power stage enabled so that the output is regulated throughout the ramp.

The number of steps and the spacing between them are worked out from the programmed time. The spacing is never longer than 100 µs. Rise or fall times shorter than 250 µs skip the ramp entirely. Dropping the run pin or the on command gives a ramp down over the fall time. A fault, or a low GPIO while GPIO response is enabled, cuts the PWM enable in the same cycle and skips the ramp down. All times are counted in microseconds from a tick that a clock divider produces.

Top module: `softramp_seq`

## Requirements
- R1: The block leaves OFF only when run_pin, cmd_on, init_done and vin_ok are all high and no shutdown condition is active. Otherwise it stays in OFF with target_code 0 and pwm_en 0.
- R2: After a start the block stays in WAIT_DELAY for ton_delay_us microseconds, with pwm_en low, before any ramp begins.
- R3: Soft-start begins at code 0. It then climbs in ceil(rise_us/100) steps, with a minimum of 1 step. Each step except the last adds floor(setpoint/steps). The last step lands exactly on setpoint, and the state then becomes ON.
- R4: While ramping, two consecutive steps are never more than 100 µs apart. The whole ramp takes no longer than the programmed time.
- R5: A rise_us below 250 skips the ramp. The block goes from WAIT_DELAY straight to ON with target_code equal to setpoint.
- R6: In RAMP_UP or ON, a low run_pin or a low cmd_on starts a ramp down over fall_us, using the same step rule as R3. pwm_en stays high until target_code reaches 0, and the block then returns to OFF. A fall_us below 250 sends the block to OFF with code 0 in one cycle.
- R7: The shutdown condition is fault, or gpio_low while gpio_resp_en is set. It drives pwm_en low in the same cycle and forces OFF with target_code 0 on the next clock edge. This holds in every state and aborts any ramp in progress.
- R8: After a shutdown, no new start is accepted until the run request (run_pin and cmd_on) has gone low and then high again.
- R9: The state port encodes OFF=0, WAIT_DELAY=1, RAMP_UP=2, ON=3 and RAMP_DOWN=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_pin | input | 1 | Run pin level |
| cmd_on | input | 1 | On/off command, 1 = on |
| init_done | input | 1 | Initialisation finished |
| vin_ok | input | 1 | Input voltage above turn-on threshold |
| fault | input | 1 | Fault shutdown request |
| gpio_low | input | 1 | GPIO pin pulled low |
| gpio_resp_en | input | 1 | Enable shutdown on GPIO low |
| setpoint | input | CODE_W | Commanded target code |
| ton_delay_us | input | TIME_W | Turn-on delay in µs |
| rise_us | input | TIME_W | Rise time in µs |
| fall_us | input | TIME_W | Fall time in µs |
| target_code | output | CODE_W | Ramped target-voltage code |
| pwm_en | output | 1 | Power stage enable |
| state | output | 3 | Sequencer state per R9 |

## Verification
The bench uses a rise time that does not divide evenly, so the increment is truncated. This catches a design that stops one step short of the setpoint or overshoots it on the last step. It also checks that step spacing stays within 100 µs over a long ramp, so a divider that assumes a fixed step count would fail. The bypass threshold, the same-cycle PWM cut on fault and GPIO, and the GPIO enable bit that gates that cut are each tested at the ports. A missing re-arm latch would let the block restart on its own after a fault clears, and the bench is written to catch that.

// File: rtl/softramp_pkg.sv
// Package: shared state encoding for the ramp sequencer.
// Assumes: 3-bit state port, values fixed because software observes them.
package softramp_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_UP    = 3'd2,
        ST_ON    = 3'd3,
        ST_DOWN  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/softramp_tick.sv
// Module: softramp_tick
// Produces a one-cycle pulse every CLK_PER_US clocks (the 1 us time base).
// Assumes: CLK_PER_US >= 1; free-running from reset.
module softramp_tick #(
    parameter int CLK_PER_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    generate
        if (CLK_PER_US == 1) begin : g_every
            assign tick = rst_n;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            // divide the clock down to a microsecond pulse
            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else if (cnt_q == CW'(CLK_PER_US - 1)) cnt_q <= '0;
                else cnt_q <= cnt_q + CW'(1);
            end
            assign tick = (cnt_q == CW'(CLK_PER_US - 1));
        end
    endgenerate
endmodule

// File: rtl/softramp_plan.sv
// Module: softramp_plan
// Combinational ramp planner. From a ramp time and a code span it returns
// the step count, the step interval in us and the per-step increment.
// Assumes: MAX_STEP_US > 0; the result is latched by the caller at ramp start.
module softramp_plan #(
    parameter int CODE_W      = 12,
    parameter int TIME_W      = 16,
    parameter int MAX_STEP_US = 100,
    parameter int MIN_RAMP_US = 250
) (
    input  logic [TIME_W-1:0] time_us,
    input  logic [CODE_W-1:0] span,
    output logic [TIME_W-1:0] nsteps,
    output logic [TIME_W-1:0] interval,
    output logic [CODE_W-1:0] inc,
    output logic              bypass
);
    localparam int DW = TIME_W + CODE_W;

    logic [TIME_W:0]   n_raw;
    logic [TIME_W-1:0] iv_raw;
    logic [DW-1:0]     inc_full;

    // step count rounded up, interval rounded down, increment truncated
    always_comb begin
        n_raw    = ({1'b0, time_us} + (TIME_W+1)'(MAX_STEP_US - 1)) / (TIME_W+1)'(MAX_STEP_US);
        nsteps   = (n_raw == '0) ? TIME_W'(1) : n_raw[TIME_W-1:0];
        iv_raw   = time_us / nsteps;
        interval = (iv_raw == '0) ? TIME_W'(1) : iv_raw;
        inc_full = DW'(span) / DW'(nsteps);
        inc      = inc_full[CODE_W-1:0];
        bypass   = (time_us < TIME_W'(MIN_RAMP_US));
    end
endmodule

// File: rtl/softramp_core.sv
// Module: softramp_core
// Sequencing state machine: start gating, turn-on delay, stepped ramp up,
// hold, stepped ramp down, immediate shutdown and re-arm after shutdown.
// Assumes: tick is a 1-cycle pulse per us; plan_* is valid for the
// time/span selected by plan_down in the current cycle.
module softramp_core
    import softramp_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int TIME_W      = 16,
    parameter int CLK_PER_US  = 4,
    parameter int MAX_STEP_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic              init_done,
    input  logic              vin_ok,
    input  logic              kill,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [TIME_W-1:0] ton_delay_us,
    input  logic [TIME_W-1:0] plan_n,
    input  logic [TIME_W-1:0] plan_iv,
    input  logic [CODE_W-1:0] plan_inc,
    input  logic              plan_byp,
    output logic              plan_down,
    output logic [CODE_W-1:0] target_q,
    output seq_state_e        state_q
);
    logic [CODE_W-1:0] sp_q;
    logic [CODE_W-1:0] inc_q;
    logic [TIME_W-1:0] nsteps_q;
    logic [TIME_W-1:0] interval_q;
    logic [TIME_W-1:0] tick_cnt_q;
    logic [TIME_W-1:0] step_idx_q;
    logic [TIME_W-1:0] dly_cnt_q;
    logic              armed_q;
    logic              start_ok;
    logic              ramping;
    logic              step_fire;
    logic              last_step;
    logic              going_down;

    assign ramping    = (state_q == ST_UP) || (state_q == ST_DOWN);
    assign step_fire  = ramping && tick && (tick_cnt_q == interval_q - TIME_W'(1));
    assign last_step  = (step_idx_q + TIME_W'(1) == nsteps_q);
    assign plan_down  = (state_q == ST_UP) || (state_q == ST_ON);
    assign going_down = !req && plan_down;
    assign start_ok   = req && init_done && vin_ok && armed_q && !kill;

    // re-arm latch: cleared by shutdown, set again once the request drops
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= 1'b1;
        else if (kill) armed_q <= 1'b0;
        else if (!req) armed_q <= 1'b1;
    end

    // main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            target_q   <= '0;
            sp_q       <= '0;
            inc_q      <= '0;
            nsteps_q   <= TIME_W'(1);
            interval_q <= TIME_W'(1);
            tick_cnt_q <= '0;
            step_idx_q <= '0;
            dly_cnt_q  <= '0;
        end else if (kill) begin
            state_q  <= ST_OFF;
            target_q <= '0;
        end else if (going_down) begin
            nsteps_q   <= plan_n;
            interval_q <= plan_iv;
            inc_q      <= plan_inc;
            tick_cnt_q <= '0;
            step_idx_q <= '0;
            if (plan_byp) begin
                target_q <= '0;
                state_q  <= ST_OFF;
            end else begin
                state_q  <= ST_DOWN;
            end
        end else begin
            case (state_q)
                ST_OFF: begin
                    target_q <= '0;
                    if (start_ok) begin
                        state_q   <= ST_WAIT;
                        dly_cnt_q <= '0;
                    end
                end
                ST_WAIT: begin
                    if (!req) begin
                        state_q <= ST_OFF;
                    end else if (dly_cnt_q >= ton_delay_us) begin
                        sp_q       <= setpoint;
                        nsteps_q   <= plan_n;
                        interval_q <= plan_iv;
                        inc_q      <= plan_inc;
                        tick_cnt_q <= '0;
                        step_idx_q <= '0;
                        if (plan_byp) begin
                            target_q <= setpoint;
                            state_q  <= ST_ON;
                        end else begin
                            target_q <= '0;
                            state_q  <= ST_UP;
                        end
                    end else if (tick) begin
                        dly_cnt_q <= dly_cnt_q + TIME_W'(1);
                    end
                end
                ST_UP: begin
                    if (step_fire) begin
                        tick_cnt_q <= '0;
                        step_idx_q <= step_idx_q + TIME_W'(1);
                        if (last_step) begin
                            target_q <= sp_q;
                            state_q  <= ST_ON;
                        end else begin
                            target_q <= target_q + inc_q;
                        end
                    end else if (tick) begin
                        tick_cnt_q <= tick_cnt_q + TIME_W'(1);
                    end
                end
                ST_DOWN: begin
                    if (step_fire) begin
                        tick_cnt_q <= '0;
                        step_idx_q <= step_idx_q + TIME_W'(1);
                        if (last_step) begin
                            target_q <= '0;
                            state_q  <= ST_OFF;
                        end else begin
                            target_q <= target_q - inc_q;
                        end
                    end else if (tick) begin
                        tick_cnt_q <= tick_cnt_q + TIME_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    int unsigned gap_q;
    // cycles since the last step while ramping (window checker)
    always_ff @(posedge clk) begin
        if (!rst_n || !ramping || step_fire) gap_q <= 0;
        else gap_q <= gap_q + 1;
    end

    p_step_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= unsigned'(MAX_STEP_US * CLK_PER_US));

    p_kill_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (state_q == ST_OFF && target_q == '0));

    p_up_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && req && !kill) |=> (target_q >= $past(target_q)));

    p_up_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && step_fire && last_step && req && !kill)
        |=> (state_q == ST_ON && target_q == $past(sp_q)));

    p_down_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |=> (state_q != ST_OFF || target_q == '0));

    p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (state_q == ST_OFF || $past(req && init_done && vin_ok)));
endmodule

// File: rtl/softramp_seq.sv
// Module: softramp_seq (top)
// Soft-start/stop sequencer for one regulator output: combines the
// microsecond tick, the ramp planner and the sequencing core, and gates
// the PWM enable with the shutdown condition in the same cycle.
// Assumes: all inputs synchronous to clk.
module softramp_seq
    import softramp_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int TIME_W      = 16,
    parameter int CLK_PER_US  = 4,
    parameter int MAX_STEP_US = 100,
    parameter int MIN_RAMP_US = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_pin,
    input  logic              cmd_on,
    input  logic              init_done,
    input  logic              vin_ok,
    input  logic              fault,
    input  logic              gpio_low,
    input  logic              gpio_resp_en,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [TIME_W-1:0] ton_delay_us,
    input  logic [TIME_W-1:0] rise_us,
    input  logic [TIME_W-1:0] fall_us,
    output logic [CODE_W-1:0] target_code,
    output logic              pwm_en,
    output logic [2:0]        state
);
    logic              tick;
    logic              kill;
    logic              req;
    logic              plan_down;
    logic [TIME_W-1:0] plan_time;
    logic [CODE_W-1:0] plan_span;
    logic [TIME_W-1:0] plan_n;
    logic [TIME_W-1:0] plan_iv;
    logic [CODE_W-1:0] plan_inc;
    logic              plan_byp;
    seq_state_e        st;

    assign kill = fault || (gpio_low && gpio_resp_en);
    assign req  = run_pin && cmd_on;

    softramp_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // select the ramp being planned: down from current code, or up to setpoint
    always_comb begin
        plan_time = plan_down ? fall_us : rise_us;
        plan_span = plan_down ? target_code : setpoint;
    end

    softramp_plan #(
        .CODE_W(CODE_W), .TIME_W(TIME_W),
        .MAX_STEP_US(MAX_STEP_US), .MIN_RAMP_US(MIN_RAMP_US)
    ) plan_i (
        .time_us  (plan_time),
        .span     (plan_span),
        .nsteps   (plan_n),
        .interval (plan_iv),
        .inc      (plan_inc),
        .bypass   (plan_byp)
    );

    softramp_core #(
        .CODE_W(CODE_W), .TIME_W(TIME_W),
        .CLK_PER_US(CLK_PER_US), .MAX_STEP_US(MAX_STEP_US)
    ) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .req          (req),
        .init_done    (init_done),
        .vin_ok       (vin_ok),
        .kill         (kill),
        .setpoint     (setpoint),
        .ton_delay_us (ton_delay_us),
        .plan_n       (plan_n),
        .plan_iv      (plan_iv),
        .plan_inc     (plan_inc),
        .plan_byp     (plan_byp),
        .plan_down    (plan_down),
        .target_q     (target_code),
        .state_q      (st)
    );

    assign state  = st;
    assign pwm_en = (st == ST_UP || st == ST_ON || st == ST_DOWN) && !kill;
endmodule

// File: tb/softramp_seq_tb.sv
module softramp_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 4;
    localparam int CW = 12;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_pin = 0, cmd_on = 0, init_done = 0, vin_ok = 0;
    logic fault = 0, gpio_low = 0, gpio_resp_en = 0;
    logic [CW-1:0] setpoint = '0;
    logic [TW-1:0] ton_delay_us = '0, rise_us = '0, fall_us = '0;
    logic [CW-1:0] target_code;
    logic pwm_en;
    logic [2:0] state;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    softramp_seq #(.CODE_W(CW), .TIME_W(TW), .CLK_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_pin(run_pin), .cmd_on(cmd_on),
        .init_done(init_done), .vin_ok(vin_ok), .fault(fault),
        .gpio_low(gpio_low), .gpio_resp_en(gpio_resp_en),
        .setpoint(setpoint), .ton_delay_us(ton_delay_us),
        .rise_us(rise_us), .fall_us(fall_us),
        .target_code(target_code), .pwm_en(pwm_en), .state(state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold OFF, then check state/code/pwm
    task automatic expect_off(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (state != 3'd0 || pwm_en || target_code != 0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset;
        check(state == 3'd0, "R9 reset state OFF", state, 0);
        check(target_code == 0, "R1 reset code", target_code, 0);
        check(pwm_en == 0, "R1 reset pwm", pwm_en, 0);
    endtask

    task automatic t_gating;
        setpoint = 12'd1000; ton_delay_us = 0; rise_us = 1000; fall_us = 1000;
        run_pin = 1; cmd_on = 1; init_done = 1; vin_ok = 0;
        expect_off(50, "R1 vin_ok low blocks start");
        vin_ok = 1; init_done = 0;
        expect_off(50, "R1 init_done low blocks start");
        cmd_on = 0; init_done = 1;
        expect_off(50, "R1 cmd_on low blocks start");
        cmd_on = 1; run_pin = 0;
        expect_off(50, "R1 run_pin low blocks start");
    endtask

    // start a ramp-up and measure it; returns with state ON
    task automatic t_rampup(input int sp, input int rise, input int dly,
                            input int exp_steps, input string tag);
        int wait_c = 0, bad_pwm = 0, steps = 0, gap = 0, maxgap = 0, dur = 0;
        int prev;
        setpoint = sp[CW-1:0]; rise_us = rise[TW-1:0]; ton_delay_us = dly[TW-1:0];
        run_pin = 1; cmd_on = 1;
        @(negedge clk);
        check(state == 3'd1, {"R9 WAIT_DELAY code ", tag}, state, 1);
        while (state == 3'd1 && wait_c < 100000) begin
            if (pwm_en) bad_pwm++;
            wait_c++;
            @(negedge clk);
        end
        check(bad_pwm == 0, {"R2 pwm low in delay ", tag}, bad_pwm, 0);
        check(wait_c >= dly*CPU - CPU && wait_c <= dly*CPU + 2*CPU,
              {"R2 delay length ", tag}, wait_c, dly*CPU);
        check(state == 3'd2, {"R9 RAMP_UP code ", tag}, state, 2);
        check(target_code == 0, {"R3 ramp starts at 0 ", tag}, target_code, 0);
        prev = target_code;
        while (state == 3'd2 && dur < 100000) begin
            @(negedge clk);
            dur++; gap++;
            if (target_code != prev) begin
                steps++;
                if (gap > maxgap) maxgap = gap;
                gap = 0;
                prev = target_code;
            end
            if (!pwm_en) bad_pwm++;
        end
        check(bad_pwm == 0, {"R3 pwm high while ramping ", tag}, bad_pwm, 0);
        check(state == 3'd3, {"R9 ON code ", tag}, state, 3);
        check(target_code == sp, {"R3 lands on setpoint ", tag}, target_code, sp);
        check(steps == exp_steps, {"R3 step count ", tag}, steps, exp_steps);
        check(maxgap <= 100*CPU, {"R4 step gap ", tag}, maxgap, 100*CPU);
        check(dur <= rise*CPU + CPU && dur >= (rise - exp_steps)*CPU - CPU,
              {"R4 ramp duration ", tag}, dur, rise*CPU);
    endtask

    // from ON, drop the request and measure the ramp down
    task automatic t_rampdown(input int fall, input int exp_steps, input bit use_run,
                              input string tag);
        int steps = 0, gap = 0, maxgap = 0, dur = 0, bad_pwm = 0, prev;
        fall_us = fall[TW-1:0];
        if (use_run) run_pin = 0; else cmd_on = 0;
        @(negedge clk);
        check(state == 3'd4, {"R9 RAMP_DOWN code ", tag}, state, 4);
        prev = target_code;
        while (state == 3'd4 && dur < 100000) begin
            if (!pwm_en) bad_pwm++;
            @(negedge clk);
            dur++; gap++;
            if (target_code != prev) begin
                steps++;
                if (gap > maxgap) maxgap = gap;
                gap = 0;
                prev = target_code;
            end
        end
        check(bad_pwm == 0, {"R6 pwm high until zero ", tag}, bad_pwm, 0);
        check(state == 3'd0 && target_code == 0 && !pwm_en,
              {"R6 ends OFF at zero ", tag}, target_code, 0);
        check(steps == exp_steps, {"R6 down steps ", tag}, steps, exp_steps);
        check(maxgap <= 100*CPU, {"R4 down gap ", tag}, maxgap, 100*CPU);
        run_pin = 1; cmd_on = 1;
        cyc(1);
        run_pin = 0; cmd_on = 0;
        cyc(5);
    endtask

    task automatic t_bypass;
        int c = 0, saw_up = 0;
        setpoint = 12'd700; rise_us = 249; ton_delay_us = 10;
        run_pin = 1; cmd_on = 1;
        @(negedge clk);
        while (state != 3'd3 && c < 10000) begin
            if (state == 3'd2) saw_up++;
            c++;
            @(negedge clk);
        end
        check(saw_up == 0, "R5 no RAMP_UP under 250us", saw_up, 0);
        check(target_code == 700 && pwm_en, "R5 jump to setpoint", target_code, 700);
        fall_us = 100;
        cmd_on = 0;
        @(negedge clk);
        check(state == 3'd0 && target_code == 0 && !pwm_en,
              "R6 short fall goes straight OFF", state, 0);
        run_pin = 0;
        cyc(3);
    endtask

    task automatic t_kill_rearm;
        int guard = 0;
        setpoint = 12'd1000; rise_us = 1000; ton_delay_us = 0;
        run_pin = 1; cmd_on = 1;
        while (!(state == 3'd2 && target_code >= 300) && guard < 20000) begin
            @(negedge clk); guard++;
        end
        fault = 1;
        #1;
        check(pwm_en == 0, "R7 fault cuts pwm same cycle", pwm_en, 0);
        @(negedge clk);
        check(state == 3'd0 && target_code == 0, "R7 fault aborts ramp to OFF", target_code, 0);
        fault = 0;
        expect_off(60, "R8 no restart while request held");
        run_pin = 0; cyc(2); run_pin = 1;
        @(negedge clk);
        check(state == 3'd1, "R8 restart after request toggles", state, 1);
        guard = 0;
        while (state != 3'd3 && guard < 20000) begin @(negedge clk); guard++; end
        gpio_resp_en = 0; gpio_low = 1;
        cyc(20);
        check(state == 3'd3 && pwm_en, "R7 gpio low ignored when disabled", state, 3);
        gpio_resp_en = 1;
        #1;
        check(pwm_en == 0, "R7 gpio low cuts pwm same cycle", pwm_en, 0);
        @(negedge clk);
        check(state == 3'd0 && target_code == 0, "R7 gpio shutdown no soft-stop", state, 0);
        gpio_low = 0; gpio_resp_en = 0;
        run_pin = 0; cmd_on = 0;
        cyc(3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_gating();
        run_pin = 0; cmd_on = 0; init_done = 1; vin_ok = 1; cyc(2);
        fall_us = 1000;
        t_rampup(1000, 1000, 50, 10, "even");
        t_rampdown(1000, 10, 1'b1, "run_pin");
        t_rampup(1000, 1050, 0, 11, "odd");
        t_rampdown(1000, 10, 1'b0, "cmd_off");
        t_bypass();
        t_kill_rearm();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule